// File: doc/BRIEF.md
# SD Bus Clock Divider

This block derives the clock driven onto a memory-card bus from the host clock. A 32-bit control word selects what the card clock does. It can be stopped, gated by bus activity, passed straight through from the host clock, or divided by an even ratio set by an 8-bit field. The control word is sampled into a local register, and the block acts on that registered copy.

Besides the card clock, the block gives the command path a one-host-cycle strobe. The strobe announces the next rising edge of the card clock, so the command shifter can advance exactly once per card bit without using the card clock as a clock. A wide-bus select bit rides along in the same word. It is held and exported for the data path, and it does not touch clock generation.

In power-save mode, the command and data paths report bus activity on a busy input. While the bus is idle, the card clock parks low after finishing any high phase already under way. When the divide field is rewritten while the clock runs, the new ratio is taken up only at a half-period boundary, so no phase is ever cut short.

Top module: `sd_bus_clk_gen`

## Requirements
- R1: Control bit 8 is the enable; while the registered copy has it clear, `card_clk` is low and `rise_stb` is low.
- R2: Control bit 9 selects power-save. With power-save set, the clock pauses low while `bus_busy` is low and runs while it is high. A high phase already under way when `bus_busy` drops still lasts its full N+1 host cycles.
- R3: Control bit 10 selects bypass. In bypass, `card_clk` follows the host clock and the divide field has no effect.
- R4: Control bits 7:0 hold N. Outside bypass, the card clock's high and low phases each last N+1 host cycles, which gives a period of 2×(N+1).
- R5: N=255 gives phases of 256 host cycles, a division by 512.
- R6: Control bit 11 is exported on `wide_bus` and has no effect on the card clock.
- R7: Outside bypass, `rise_stb` is high for exactly the one host cycle that ends in a rising edge of `card_clk`, and at no other time. In bypass with the clock running, it is high every cycle.
- R8: A change of N takes effect only at a half-period boundary. Every completed phase therefore lasts either old N+1 or new N+1 cycles.
- R9: Reset clears the control register, so `card_clk`, `rise_stb` and `wide_bus` are low out of reset. A control value acts one host cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Clock control word (bits 7:0 divide, 8 enable, 9 power-save, 10 bypass, 11 wide bus) |
| bus_busy | input | 1 | Command or data path active |
| card_clk | output | 1 | Clock to the card bus |
| rise_stb | output | 1 | One-cycle strobe ahead of each card clock rising edge |
| wide_bus | output | 1 | Registered wide-bus select |

## Verification
Two functions can collide in one cycle. In the first collision, the power-save gate closes while the divider is partway through a high phase. The bench provokes this by dropping `bus_busy` on the cycle the card clock rises. It then judges the result by counting the remaining high cycles, which must equal N, and by checking that no further rising edge appears.

In the second collision, a divide-field rewrite lands in the middle of a phase. The bench rewrites the field in both directions, from small to large and from large to small. It judges the result by requiring every completed phase to be exactly old N+1 or new N+1 cycles long, with the strobe still paired one-to-one with rising edges.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int CTRL_W   = 32;
    localparam int DIV_W    = 8;
    localparam int BIT_EN   = 8;
    localparam int BIT_PS   = 9;
    localparam int BIT_BYP  = 10;
    localparam int BIT_WIDE = 11;

    // Decoded clock configuration
    typedef struct packed {
        logic             en;
        logic             psave;
        logic             bypass;
        logic             wide;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;

    // Divider state: phase counter, latched limit, output level
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
        logic             phase;
    } div_state_t;

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
    import sdclk_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ctrl_i,
    output clk_cfg_t      cfg_o
);

    clk_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d        = cfg_q;
        cfg_d.en     = ctrl_i[BIT_EN];
        cfg_d.psave  = ctrl_i[BIT_PS];
        cfg_d.bypass = ctrl_i[BIT_BYP];
        cfg_d.wide   = ctrl_i[BIT_WIDE];
        cfg_d.div    = ctrl_i[DIV_W-1:0];
    end

    // R9: register clears to zero, clock starts disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_cfg_t cfg_i,
    input  logic     busy_i,
    output logic     div_clk_o,
    output logic     rise_o
);

    div_state_t st_d, st_q;
    logic       run;
    logic       at_lim;

    always_comb begin
        run    = cfg_i.en && !cfg_i.bypass && (!cfg_i.psave || busy_i);
        at_lim = (st_q.cnt == st_q.lim);
        st_d   = st_q;
        if (!cfg_i.en || cfg_i.bypass) begin
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
            st_d.lim   = cfg_i.div;
        end else if (st_q.phase) begin
            // a high phase always runs to its end
            if (at_lim) begin
                st_d.phase = 1'b0;
                st_d.cnt   = '0;
                st_d.lim   = cfg_i.div;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (run) begin
            if (at_lim) begin
                st_d.phase = 1'b1;
                st_d.cnt   = '0;
                st_d.lim   = cfg_i.div;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        rise_o = run && !st_q.phase && at_lim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_clk_o = st_q.phase;

    a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> !st_q.phase);

    a_r3_bypass_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.bypass |=> !st_q.phase);

    a_r2_idle_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && cfg_i.psave && !cfg_i.bypass && !busy_i && !st_q.phase)
        |=> !st_q.phase);

    a_r7_strobe_then_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> st_q.phase);

    a_r8_limit_held_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && !cfg_i.bypass && (st_q.cnt != st_q.lim)) |=> $stable(st_q.lim));

endmodule

// File: rtl/sdclk_out.sv
module sdclk_out
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_cfg_t cfg_i,
    input  logic     busy_i,
    input  logic     div_clk_i,
    input  logic     div_rise_i,
    output logic     card_clk_o,
    output logic     rise_o
);

    logic byp_run;
    logic gate_d, gate_q;

    always_comb begin
        byp_run = cfg_i.en && cfg_i.bypass && (!cfg_i.psave || busy_i);
        gate_d  = byp_run;
    end

    // gate enable changes only while the host clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign card_clk_o = gate_q ? clk : div_clk_i;
    assign rise_o     = byp_run || div_rise_i;

    a_r1_no_strobe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |-> !rise_o);

endmodule

// File: rtl/sd_bus_clk_gen.sv
module sd_bus_clk_gen
    import sdclk_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ctrl_word,
    input  logic          bus_busy,
    output logic          card_clk,
    output logic          rise_stb,
    output logic          wide_bus
);

    clk_cfg_t cfg;
    logic     div_clk;
    logic     div_rise;

    sdclk_cfg_reg #(.CW(CW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (ctrl_word),
        .cfg_o  (cfg)
    );

    sdclk_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .busy_i    (bus_busy),
        .div_clk_o (div_clk),
        .rise_o    (div_rise)
    );

    sdclk_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .busy_i     (bus_busy),
        .div_clk_i  (div_clk),
        .div_rise_i (div_rise),
        .card_clk_o (card_clk),
        .rise_o     (rise_stb)
    );

    // R6: wide-bus select is only carried through
    assign wide_bus = cfg.wide;

endmodule

// File: tb/tb_sd_bus_clk_gen.sv
module tb_sd_bus_clk_gen;

    localparam int CLK_PERIOD = 10;
    localparam int EN   = 32'h100;
    localparam int PS   = 32'h200;
    localparam int BYP  = 32'h400;
    localparam int WIDE = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        bus_busy = 1'b0;
    logic        card_clk, rise_stb, wide_bus;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_bus_clk_gen dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .bus_busy(bus_busy),
        .card_clk(card_clk), .rise_stb(rise_stb), .wide_bus(wide_bus)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // Samples once per cycle after the falling edge; counts complete phases
    // whose length is neither a nor b, rising edges, and strobe mismatches.
    task automatic observe(input int n, input int a, input int b,
                           output int rises, output int bad, output int stbbad);
        logic pc, ps;
        int   len;
        bit   seen;
        rises = 0; bad = 0; stbbad = 0; len = 0; seen = 0;
        @(negedge clk); #1;
        pc = card_clk; ps = rise_stb; len = 1;
        for (int i = 1; i < n; i++) begin
            @(negedge clk); #1;
            if (card_clk != pc) begin
                if (seen && len != a && len != b) bad++;
                seen = 1;
                len  = 1;
            end else begin
                len++;
            end
            if (!pc && card_clk) rises++;
            if ((!pc && card_clk) != ps) stbbad++;
            pc = card_clk; ps = rise_stb;
        end
    endtask

    initial begin
        int r, b, s, h;
        ctrl_word = EN | 3;
        tick(3);
        chk(card_clk == 0 && rise_stb == 0 && wide_bus == 0, "R9 reset outputs", card_clk, 0);
        ctrl_word = 0;
        rst_n = 1;
        tick(2);
        observe(40, 1, 1, r, b, s);
        chk(r == 0 && card_clk == 0, "R9 zero control after reset, clock off", r, 0);
        chk(s == 0 && rise_stb == 0, "R1 no strobe when disabled", s, 0);

        // R4/R7 sweep of the divide field
        for (int n = 0; n < 16; n++) begin
            ctrl_word = EN | n;
            tick(40);
            observe(8*(n+1) + 2, n+1, n+1, r, b, s);
            chk(b == 0 && r >= 3, $sformatf("R4 phase length N=%0d", n), b, 0);
            chk(s == 0, $sformatf("R7 strobe pairing N=%0d", n), s, 0);
        end

        // R5: slowest ratio
        ctrl_word = EN | 255;
        tick(520);
        observe(1540, 256, 256, r, b, s);
        chk(b == 0 && r >= 2, "R5 N=255 phases of 256", b, 0);
        chk(s == 0, "R7 strobe pairing N=255", s, 0);

        // R6: wide bus stored, clock unaffected
        ctrl_word = EN | WIDE | 3;
        tick(520);
        chk(wide_bus == 1, "R6 wide_bus exported", wide_bus, 1);
        observe(50, 4, 4, r, b, s);
        chk(b == 0 && r >= 3 && s == 0, "R6 wide bit has no effect on clock", b, 0);
        ctrl_word = EN | 3;
        tick(2);
        chk(wide_bus == 0, "R6 wide_bus cleared", wide_bus, 0);

        // R3/R7 bypass: card clock follows host clock, strobe every cycle
        ctrl_word = EN | BYP | 7;
        tick(4);
        h = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (card_clk != 1 || rise_stb != 1) h++;
            @(negedge clk); #2;
            if (card_clk != 0 || rise_stb != 1) h++;
        end
        chk(h == 0, "R3 bypass follows host clock", h, 0);
        chk(h == 0, "R7 bypass strobe every cycle", h, 0);

        // R1: clearing enable stops the clock
        ctrl_word = EN | 2;
        tick(20);
        ctrl_word = 0;
        tick(3);
        observe(40, 1, 1, r, b, s);
        chk(r == 0 && card_clk == 0 && s == 0, "R1 enable clear holds clock low", r, 0);

        // R2: power-save idle and active
        bus_busy = 0;
        ctrl_word = EN | PS | 2;
        tick(10);
        observe(40, 3, 3, r, b, s);
        chk(r == 0 && card_clk == 0, "R2 idle bus parks clock", r, 0);
        bus_busy = 1;
        observe(60, 3, 3, r, b, s);
        chk(b == 0 && r >= 5 && s == 0, "R2 busy bus runs clock", r, 10);

        // R2: busy drops on the rising edge; high phase completes
        ctrl_word = EN | PS | 5;
        tick(40);
        begin
            logic pc;
            pc = card_clk;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); #1;
                if (!pc && card_clk) break;
                pc = card_clk;
            end
        end
        bus_busy = 0;
        h = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (card_clk) h++;
        end
        chk(h == 5, "R2 high phase completes after idle", h, 5);
        observe(40, 6, 6, r, b, s);
        chk(r == 0 && card_clk == 0, "R2 no rise after idle", r, 0);
        bus_busy = 1;

        // R8: field change mid-run, both directions
        ctrl_word = EN | 2;
        tick(40);
        ctrl_word = EN | 6;
        observe(80, 3, 7, r, b, s);
        chk(b == 0 && s == 0, "R8 grow 2->6 phases in {3,7}", b, 0);
        ctrl_word = EN | 6;
        tick(5);
        ctrl_word = EN | 1;
        observe(60, 7, 2, r, b, s);
        chk(b == 0 && s == 0, "R8 shrink 6->1 phases in {7,2}", b, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule